// File: doc/BRIEF.md
# Health Packet Checker and Recovery Selector

This block watches the health reports that one monitored unit sends to its supervisor. The reports arrive as a byte stream, qualified by a valid strobe and closed by a last strobe. The block decodes the three-byte header. For a diagnostic packet it compares the reported self-test signature, the memory upset count and the supply current against the reference values that the supervisor has programmed.

For every well-formed packet the block raises a single-cycle strobe. The strobe carries a recovery command and a cause code. The possible commands are no action, reload program memory, reset then reload, and power cycle then reload. When one packet shows several faults, only the most severe action is issued.

A packet that belongs to another unit, or whose framing does not agree with its own length byte, is discarded. In that case no command is issued and a malformed indication pulses instead. The block only chooses the action: moving packets, reloading memory, switching power and supervising timeouts are done elsewhere.

Top module: `hpkt_recovery_sel`

## Requirements
- R1: While reset is asserted and after its release, `rec_valid_o` and `malformed_o` are 0 and `rec_cmd_o` and `cause_o` are 0.
- R2: A packet is a header of one-byte fields followed by payload bytes. Byte 0 is the unit identifier, which must equal parameter UNIT_ID (default 8'h5A). Byte 1 is the payload byte count. Byte 2 is the flags byte, where bit 0 = 1 marks a screech packet and bit 0 = 0 marks a diagnostic packet.
- R3: A well-formed screech packet, with any payload length, gives command 1 (reload) and cause 1. Its payload is not inspected.
- R4: A diagnostic payload is exactly 8 bytes: a 32-bit signature, then a 16-bit upset count, then a 16-bit current sample, each sent most significant byte first. If all three values are within limits, the strobe carries command 0 and cause 0.
- R5: An upset count strictly greater than `seu_thr_i` gives command 1 (reload) with cause 2. A count equal to the threshold is not a fault.
- R6: A signature different from `exp_sig_i` gives command 2 (reset then reload) with cause 3.
- R7: A current below `cur_lo_i` or above `cur_hi_i` gives command 3 (power cycle then reload) with cause 4. Both limits are themselves allowed values.
- R8: When several faults occur in one packet, the current fault wins over the signature fault, and the signature fault wins over the upset fault. The cause code is the one that belongs to the winning fault.
- R9: Three cases make a packet malformed: a wrong identifier, a total byte count different from 3 plus the length byte, or a diagnostic packet whose length byte is not 8. A malformed packet produces no strobe. Instead `malformed_o` pulses for one cycle, and the command and cause outputs stay 0.
- R10: The strobe, or the malformed pulse, is high for exactly the one cycle after the cycle that accepts the last byte. Outside that cycle the command and cause outputs are 0. Cycles with valid low inside a packet have no effect.
- R11: A packet that ends before its header is complete is malformed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_i | input | 8 | Packet byte |
| valid_i | input | 1 | Byte qualifier |
| last_i | input | 1 | Marks final byte of packet |
| exp_sig_i | input | 32 | Expected self-test signature |
| seu_thr_i | input | 16 | Upset count threshold |
| cur_lo_i | input | 16 | Lowest allowed current sample |
| cur_hi_i | input | 16 | Highest allowed current sample |
| rec_valid_o | output | 1 | Recovery decision strobe |
| rec_cmd_o | output | 2 | Recovery command: 0 none, 1 reload, 2 reset+reload, 3 power cycle+reload |
| cause_o | output | 3 | Fault cause: 0 healthy, 1 screech, 2 upset, 3 self-test, 4 current |
| malformed_o | output | 1 | Packet dropped pulse |

## Verification
The bench drives threshold and window values at their edges: an upset count equal to the threshold, and currents exactly at the upper limit and one above it. A design that used an inclusive comparison, or an exclusive window, would order needless reloads or power cycles there. Packets with several faults at once are sent to catch a wrong severity order, which would show up as a reload where a power cycle was due. Wrong identifiers, length mismatches in both directions, a diagnostic packet with a short length byte, and a two-byte fragment must all give a malformed pulse and no strobe; a design that decides on partial data would instead issue a command. Bubbles in valid inside a packet check that idle cycles do not advance the byte position, and the cycle after every strobe is checked to be quiet.

// File: rtl/hpkt_pkg.sv
package hpkt_pkg;
  typedef enum logic [1:0] {
    CMD_NONE         = 2'd0,
    CMD_RELOAD       = 2'd1,
    CMD_RESET_RELOAD = 2'd2,
    CMD_POWER_RELOAD = 2'd3
  } rec_cmd_e;

  typedef enum logic [2:0] {
    CAUSE_NONE    = 3'd0,
    CAUSE_SCREECH = 3'd1,
    CAUSE_SEU     = 3'd2,
    CAUSE_TEST    = 3'd3,
    CAUSE_CURRENT = 3'd4
  } cause_e;

  localparam int unsigned HDR_BYTES = 3;
endpackage

// File: rtl/hpkt_parser.sv
module hpkt_parser
  import hpkt_pkg::*;
#(
  parameter logic [7:0]  UNIT_ID   = 8'h5A,
  parameter int unsigned SIG_BYTES = 4,
  parameter int unsigned SEU_BYTES = 2,
  parameter int unsigned CUR_BYTES = 2,
  localparam int unsigned SIG_W = 8 * SIG_BYTES,
  localparam int unsigned SEU_W = 8 * SEU_BYTES,
  localparam int unsigned CUR_W = 8 * CUR_BYTES
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [7:0]       byte_i,
  input  logic             valid_i,
  input  logic             last_i,
  output logic             done_o,
  output logic             frame_ok_o,
  output logic             screech_o,
  output logic [SIG_W-1:0] sig_o,
  output logic [SEU_W-1:0] seu_o,
  output logic [CUR_W-1:0] cur_o
);
  localparam int unsigned PAY_BYTES = SIG_BYTES + SEU_BYTES + CUR_BYTES;
  localparam int unsigned SIG_LO    = HDR_BYTES;
  localparam int unsigned SEU_LO    = SIG_LO + SIG_BYTES;
  localparam int unsigned CUR_LO    = SEU_LO + SEU_BYTES;
  localparam int unsigned CUR_END   = CUR_LO + CUR_BYTES;
  localparam int unsigned CNT_W     = $clog2(HDR_BYTES + 256) + 1;

  logic [CNT_W-1:0] idx_q;
  logic [7:0]       id_q, id_n, len_q, len_n;
  logic             scr_q, scr_n;
  logic [SIG_W-1:0] sig_q, sig_n;
  logic [SEU_W-1:0] seu_q, seu_n;
  logic [CUR_W-1:0] cur_q, cur_n;

  // Next-state view merges the byte of this cycle, so a decision can be
  // taken on the same edge that accepts the last byte.
  always_comb begin
    id_n  = id_q;
    len_n = len_q;
    scr_n = scr_q;
    sig_n = sig_q;
    seu_n = seu_q;
    cur_n = cur_q;
    if (valid_i) begin
      if (idx_q == CNT_W'(0))      id_n  = byte_i;
      else if (idx_q == CNT_W'(1)) len_n = byte_i;
      else if (idx_q == CNT_W'(2)) scr_n = byte_i[0];
      else if (idx_q < CNT_W'(SEU_LO))  sig_n = (sig_q << 8) | SIG_W'(byte_i);
      else if (idx_q < CNT_W'(CUR_LO))  seu_n = (seu_q << 8) | SEU_W'(byte_i);
      else if (idx_q < CNT_W'(CUR_END)) cur_n = (cur_q << 8) | CUR_W'(byte_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      id_q  <= '0;
      len_q <= '0;
      scr_q <= 1'b0;
      sig_q <= '0;
      seu_q <= '0;
      cur_q <= '0;
    end else if (valid_i) begin
      id_q  <= id_n;
      len_q <= len_n;
      scr_q <= scr_n;
      sig_q <= sig_n;
      seu_q <= seu_n;
      cur_q <= cur_n;
      if (last_i)              idx_q <= '0;
      else if (idx_q != '1)    idx_q <= idx_q + CNT_W'(1);
    end
  end

  logic hdr_done, id_ok, cnt_ok, kind_ok;
  assign hdr_done = idx_q >= CNT_W'(2);
  assign id_ok    = id_n == UNIT_ID;
  assign cnt_ok   = (idx_q + CNT_W'(1)) == (CNT_W'(HDR_BYTES) + CNT_W'(len_n));
  assign kind_ok  = scr_n || (len_n == 8'(PAY_BYTES));

  assign done_o     = valid_i && last_i;
  assign frame_ok_o = hdr_done && id_ok && cnt_ok && kind_ok;
  assign screech_o  = scr_n;
  assign sig_o      = sig_n;
  assign seu_o      = seu_n;
  assign cur_o      = cur_n;

  AST_IDX_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && last_i |=> idx_q == '0); // R10
  AST_IDX_GAP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(idx_q)); // R10
endmodule

// File: rtl/hpkt_classifier.sv
module hpkt_classifier
  import hpkt_pkg::*;
#(
  parameter int unsigned SIG_W = 32,
  parameter int unsigned SEU_W = 16,
  parameter int unsigned CUR_W = 16
) (
  input  logic             screech_i,
  input  logic [SIG_W-1:0] sig_i,
  input  logic [SEU_W-1:0] seu_i,
  input  logic [CUR_W-1:0] cur_i,
  input  logic [SIG_W-1:0] exp_sig_i,
  input  logic [SEU_W-1:0] seu_thr_i,
  input  logic [CUR_W-1:0] cur_lo_i,
  input  logic [CUR_W-1:0] cur_hi_i,
  output rec_cmd_e         cmd_o,
  output cause_e           cause_o
);
  logic cur_bad, sig_bad, seu_bad;
  assign cur_bad = (cur_i < cur_lo_i) || (cur_i > cur_hi_i);
  assign sig_bad = sig_i != exp_sig_i;
  assign seu_bad = seu_i > seu_thr_i;

  // Severity order: power cycle, reset, reload.
  always_comb begin
    if (screech_i) begin
      cmd_o = CMD_RELOAD;       cause_o = CAUSE_SCREECH;
    end else if (cur_bad) begin
      cmd_o = CMD_POWER_RELOAD; cause_o = CAUSE_CURRENT;
    end else if (sig_bad) begin
      cmd_o = CMD_RESET_RELOAD; cause_o = CAUSE_TEST;
    end else if (seu_bad) begin
      cmd_o = CMD_RELOAD;       cause_o = CAUSE_SEU;
    end else begin
      cmd_o = CMD_NONE;         cause_o = CAUSE_NONE;
    end
  end
endmodule

// File: rtl/hpkt_recovery_sel.sv
module hpkt_recovery_sel
  import hpkt_pkg::*;
#(
  parameter logic [7:0]  UNIT_ID   = 8'h5A,
  parameter int unsigned SIG_BYTES = 4,
  parameter int unsigned SEU_BYTES = 2,
  parameter int unsigned CUR_BYTES = 2,
  localparam int unsigned SIG_W = 8 * SIG_BYTES,
  localparam int unsigned SEU_W = 8 * SEU_BYTES,
  localparam int unsigned CUR_W = 8 * CUR_BYTES
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [7:0]       byte_i,
  input  logic             valid_i,
  input  logic             last_i,
  input  logic [SIG_W-1:0] exp_sig_i,
  input  logic [SEU_W-1:0] seu_thr_i,
  input  logic [CUR_W-1:0] cur_lo_i,
  input  logic [CUR_W-1:0] cur_hi_i,
  output logic             rec_valid_o,
  output logic [1:0]       rec_cmd_o,
  output logic [2:0]       cause_o,
  output logic             malformed_o
);
  logic             done, frame_ok, screech;
  logic [SIG_W-1:0] sig;
  logic [SEU_W-1:0] seu;
  logic [CUR_W-1:0] cur;
  rec_cmd_e         cmd;
  cause_e           cause;

  hpkt_parser #(
    .UNIT_ID  (UNIT_ID),
    .SIG_BYTES(SIG_BYTES),
    .SEU_BYTES(SEU_BYTES),
    .CUR_BYTES(CUR_BYTES)
  ) u_parser (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .byte_i    (byte_i),
    .valid_i   (valid_i),
    .last_i    (last_i),
    .done_o    (done),
    .frame_ok_o(frame_ok),
    .screech_o (screech),
    .sig_o     (sig),
    .seu_o     (seu),
    .cur_o     (cur)
  );

  hpkt_classifier #(
    .SIG_W(SIG_W),
    .SEU_W(SEU_W),
    .CUR_W(CUR_W)
  ) u_classifier (
    .screech_i(screech),
    .sig_i    (sig),
    .seu_i    (seu),
    .cur_i    (cur),
    .exp_sig_i(exp_sig_i),
    .seu_thr_i(seu_thr_i),
    .cur_lo_i (cur_lo_i),
    .cur_hi_i (cur_hi_i),
    .cmd_o    (cmd),
    .cause_o  (cause)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rec_valid_o <= 1'b0;
      rec_cmd_o   <= '0;
      cause_o     <= '0;
      malformed_o <= 1'b0;
    end else begin
      rec_valid_o <= done && frame_ok;
      malformed_o <= done && !frame_ok;
      rec_cmd_o   <= (done && frame_ok) ? cmd   : CMD_NONE;
      cause_o     <= (done && frame_ok) ? cause : CAUSE_NONE;
    end
  end

  AST_STROBE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o |=> !rec_valid_o); // R10
  AST_STROBE_AFTER_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rec_valid_o || malformed_o) |-> $past(valid_i && last_i)); // R10
  AST_DROP_NO_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    malformed_o |-> (!rec_valid_o && rec_cmd_o == 2'd0)); // R9
  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rec_valid_o |-> (rec_cmd_o == 2'd0 && cause_o == 3'd0)); // R10
  AST_CAUSE_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o |-> ((cause_o == 3'd0) == (rec_cmd_o == 2'd0))); // R4
  AST_POWER_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rec_valid_o && rec_cmd_o == 2'd3) |-> cause_o == 3'd4); // R8
endmodule

// File: tb/hpkt_recovery_sel_test.sv
module hpkt_recovery_sel_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0]  ID  = 8'h5A;
  localparam logic [31:0] SIG = 32'hC0DE_1234;
  localparam logic [15:0] THR = 16'd100;
  localparam logic [15:0] LO  = 16'd200;
  localparam logic [15:0] HI  = 16'd800;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  byte_i = '0;
  logic        valid_i = 1'b0;
  logic        last_i = 1'b0;
  logic        rec_valid_o, malformed_o;
  logic [1:0]  rec_cmd_o;
  logic [2:0]  cause_o;

  int checks = 0;
  int fails  = 0;
  bit done_flag = 0;
  logic [7:0] pkt_q [$];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  hpkt_recovery_sel uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .byte_i(byte_i), .valid_i(valid_i),
    .last_i(last_i), .exp_sig_i(SIG), .seu_thr_i(THR), .cur_lo_i(LO),
    .cur_hi_i(HI), .rec_valid_o(rec_valid_o), .rec_cmd_o(rec_cmd_o),
    .cause_o(cause_o), .malformed_o(malformed_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done_flag) begin
      done_flag = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  task automatic build_dar(input logic [7:0] id, input logic [7:0] len,
                           input logic [31:0] sig, input logic [15:0] seu,
                           input logic [15:0] cur);
    pkt_q.delete();
    pkt_q.push_back(id); pkt_q.push_back(len); pkt_q.push_back(8'h00);
    for (int i = 3; i >= 0; i--) pkt_q.push_back(sig[8*i +: 8]);
    pkt_q.push_back(seu[15:8]); pkt_q.push_back(seu[7:0]);
    pkt_q.push_back(cur[15:8]); pkt_q.push_back(cur[7:0]);
  endtask

  task automatic run_pkt(input bit gap, input bit ev, input int ecmd,
                         input int ecause, input bit em, input string tag);
    for (int i = 0; i < pkt_q.size(); i++) begin
      @(negedge clk_i);
      valid_i = 1'b1; byte_i = pkt_q[i]; last_i = (i == pkt_q.size() - 1);
      if (gap && i != pkt_q.size() - 1) begin
        @(negedge clk_i);
        valid_i = 1'b0; byte_i = 8'hFF; last_i = 1'b1;
      end
    end
    @(negedge clk_i);
    valid_i = 1'b0; last_i = 1'b0;
    chk(rec_valid_o == ev, {tag, " strobe"}, rec_valid_o, ev);
    chk(rec_cmd_o == 2'(ecmd), {tag, " cmd"}, rec_cmd_o, ecmd);
    chk(cause_o == 3'(ecause), {tag, " cause"}, cause_o, ecause);
    chk(malformed_o == em, {tag, " malformed"}, malformed_o, em);
    @(negedge clk_i);
    chk(!rec_valid_o && !malformed_o && rec_cmd_o == 0,
        "R10 quiet after strobe", {rec_valid_o, malformed_o}, 0);
  endtask

  task automatic t_reset();
    chk(!rec_valid_o && !malformed_o, "R1 flags in reset", {rec_valid_o, malformed_o}, 0);
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i);
    chk(rec_cmd_o == 0 && cause_o == 0 && !rec_valid_o, "R1 after release",
        {rec_cmd_o, cause_o}, 0);
  endtask

  task automatic t_healthy();
    build_dar(ID, 8, SIG, THR, LO);     run_pkt(0, 1, 0, 0, 0, "R4 healthy");
    build_dar(ID, 8, SIG, 16'd3, 16'd500); run_pkt(1, 1, 0, 0, 0, "R10 gaps healthy");
  endtask

  task automatic t_screech();
    pkt_q.delete();
    pkt_q.push_back(ID); pkt_q.push_back(8'd2); pkt_q.push_back(8'h01);
    pkt_q.push_back(8'hAA); pkt_q.push_back(8'h55);
    run_pkt(0, 1, 1, 1, 0, "R3 screech");
    pkt_q.delete();
    pkt_q.push_back(ID); pkt_q.push_back(8'd0); pkt_q.push_back(8'h03);
    run_pkt(0, 1, 1, 1, 0, "R2 screech empty payload");
  endtask

  task automatic t_seu();
    build_dar(ID, 8, SIG, THR + 16'd1, 16'd500); run_pkt(0, 1, 1, 2, 0, "R5 seu above");
    build_dar(ID, 8, SIG, THR, 16'd500);         run_pkt(0, 1, 0, 0, 0, "R5 seu equal");
  endtask

  task automatic t_sig();
    build_dar(ID, 8, SIG ^ 32'h8000_0000, 16'd0, 16'd500);
    run_pkt(0, 1, 2, 3, 0, "R6 sig msb");
    build_dar(ID, 8, SIG ^ 32'h1, 16'd0, 16'd500);
    run_pkt(1, 1, 2, 3, 0, "R6 sig lsb");
  endtask

  task automatic t_current();
    build_dar(ID, 8, SIG, 16'd0, LO - 16'd1);  run_pkt(0, 1, 3, 4, 0, "R7 below");
    build_dar(ID, 8, SIG, 16'd0, HI);          run_pkt(0, 1, 0, 0, 0, "R7 at high");
    build_dar(ID, 8, SIG, 16'd0, HI + 16'd1);  run_pkt(0, 1, 3, 4, 0, "R7 above");
  endtask

  task automatic t_priority();
    build_dar(ID, 8, ~SIG, 16'hFFFF, 16'd0);  run_pkt(0, 1, 3, 4, 0, "R8 all faults");
    build_dar(ID, 8, ~SIG, 16'hFFFF, 16'd500); run_pkt(0, 1, 2, 3, 0, "R8 sig over seu");
  endtask

  task automatic t_malformed();
    build_dar(8'h5B, 8, SIG, 16'd0, 16'd0); run_pkt(0, 0, 0, 0, 1, "R9 wrong id");
    build_dar(ID, 9, SIG, 16'd0, 16'd0);    run_pkt(0, 0, 0, 0, 1, "R9 long length");
    build_dar(ID, 8, SIG, 16'd0, 16'd0);
    void'(pkt_q.pop_back());                run_pkt(0, 0, 0, 0, 1, "R9 short count");
    build_dar(ID, 7, SIG, 16'd0, 16'd0);
    void'(pkt_q.pop_back());                run_pkt(0, 0, 0, 0, 1, "R9 dar length 7");
    pkt_q.delete();
    pkt_q.push_back(ID); pkt_q.push_back(8'd0);
    run_pkt(0, 0, 0, 0, 1, "R11 header cut");
    build_dar(ID, 8, SIG, 16'd0, 16'd500);  run_pkt(0, 1, 0, 0, 0, "R11 recovers");
  endtask

  initial begin
    repeat (50000) @(posedge clk_i);
    chk(0, "watchdog expired", 0, 1);
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    t_healthy();
    t_screech();
    t_seu();
    t_sig();
    t_current();
    t_priority();
    t_malformed();
    repeat (2) @(negedge clk_i);
    finish_up();
  end
endmodule